// File: doc/BRIEF.md
# Disk Controller Data Buffer

This block is the byte buffer that sits between the host data port of a floppy-style disk controller and its serial media path. In the disk-to-host direction, bytes from the media side are pushed in and the host pops them. In the host-to-disk direction, the host pushes bytes and the media side pops them. Occupancy is tracked as a count from 0 to `DEPTH`. A service request to the host or DMA engine is derived from that count and from a programmable threshold.

Two modes exist. In compatible mode the buffer behaves as a single byte latch, which suits parameter bytes that are handed over one at a time. In buffered mode the full depth is used, and the request is raised a threshold's worth of bytes early, which gives the host more time to respond. A configure strobe selects the mode and the threshold, and can lock the setting so that it survives a soft reset.

The command sequencer pulses `exec_start` when a command's execution phase begins. This empties the buffer and clears any error. If the disk side tries to push into a full buffer, or to pop from an empty one during a write, the block raises `term` and freezes all transfers. After a write underrun, the media side is fed 0x00 bytes so that it can finish the sector.

Top module: `dskbuf_top`

## Requirements
- R1: After hardware reset, the buffer is in compatible mode with threshold 1 and lock 0, `level` is 0, and `overrun`, `underrun` and `term` are 0. With `dir_write`=0, `svc_req` is 0. With `dir_write`=1, `svc_req` is 1.
- R2: Bytes leave in the order they were accepted. `host_rdata` and `disk_rdata` both show the oldest byte. `level` counts the accepted bytes, updates one cycle after a push or pop, and never exceeds `DEPTH` (16).
- R3: When a push and a pop are accepted in the same cycle, `level` is unchanged. This includes the case of a full buffer.
- R4: In buffered mode with `dir_write`=0 and threshold T, `svc_req` is 1 exactly when `level` >= 16 − T.
- R5: In buffered mode with `dir_write`=1 and threshold T, `svc_req` is 1 exactly when the free space 16 − `level` is at least 16 − T, that is, when `level` <= T.
- R6: In compatible mode the depth is 1. With `dir_write`=0, `svc_req` is 1 when `level` is 1. With `dir_write`=1, `svc_req` is 1 when `level` is 0.
- R7: With `dir_write`=0, a `disk_push` while `level` equals the mode's depth and with no host pop in the same cycle sets the sticky `overrun` flag. The byte is dropped.
- R8: With `dir_write`=1, a `disk_pop` while `level` is 0 sets the sticky `underrun` flag, and any host push in that cycle is discarded. While `underrun` is set, `disk_rdata` is 0x00.
- R9: `term` is 1 while `overrun` or `underrun` is set. While `term` is 1, all pushes and pops are ignored, `level` holds, and `svc_req` is 0.
- R10: `exec_start` sets `level` to 0 and clears `overrun` and `underrun` one cycle later.
- R11: `sw_reset` empties the buffer and clears both flags. It returns the buffer to compatible mode with threshold 1 only when the lock is 0. When the lock is 1, the mode and threshold are kept. `sw_reset` takes priority over `cfg_we` and `exec_start`.
- R12: A `cfg_we` strobe loads mode, threshold and lock. A threshold value of 0 is stored as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| sw_reset | input | 1 | Synchronous soft reset pulse |
| exec_start | input | 1 | Execution-phase start pulse; flushes the buffer |
| cfg_we | input | 1 | Configure strobe |
| cfg_buffered | input | 1 | 1 selects buffered mode, 0 selects compatible mode |
| cfg_thresh | input | 4 | Service threshold, 1..15 |
| cfg_lock | input | 1 | Keep the configuration across soft reset |
| dir_write | input | 1 | 1 = host to disk, 0 = disk to host |
| host_we | input | 1 | Host write to the data port |
| host_wdata | input | 8 | Host write byte |
| host_re | input | 1 | Host read from the data port |
| host_rdata | output | 8 | Oldest byte held |
| disk_push | input | 1 | Media byte arriving (disk read) |
| disk_wdata | input | 8 | Media byte value |
| disk_pop | input | 1 | Media side takes a byte (disk write) |
| disk_rdata | output | 8 | Byte to media; 0x00 after underrun |
| svc_req | output | 1 | Service request to host or DMA |
| level | output | 5 | Bytes held |
| overrun | output | 1 | Sticky overrun flag |
| underrun | output | 1 | Sticky underrun flag |
| term | output | 1 | Command termination request |

## Verification
Every registered result (`level`, `overrun`, `underrun`, and the head byte) changes at the first clock edge after the stimulus. `svc_req`, `term` and `disk_rdata` follow combinationally from that registered state and from `dir_write` in the same cycle. The bench drives inputs one time unit after a rising edge, updates its reference model at the next rising edge, and compares all outputs one time unit after that edge. Every comparison therefore sees the state exactly one edge after its stimulus.

// File: rtl/dskbuf_pkg.sv
package dskbuf_pkg;
   typedef enum logic {
      XFER_TO_HOST = 1'b0,
      XFER_TO_DISK = 1'b1
   } xfer_dir_e;

   typedef struct packed {
      logic ovr;
      logic unr;
   } err_flags_t;
endpackage

// File: rtl/dskbuf_mode.sv
module dskbuf_mode #(
   parameter int TW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sw_reset,
   input  logic          cfg_we,
   input  logic          cfg_buffered,
   input  logic [TW-1:0] cfg_thresh,
   input  logic          cfg_lock,
   output logic          buffered,
   output logic [TW-1:0] thresh
);
   localparam logic [TW-1:0] THR_MIN = TW'(1);

   logic lock_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buffered <= 1'b0;
         thresh   <= THR_MIN;
         lock_q   <= 1'b0;
      end else if (sw_reset) begin
         if (!lock_q) begin
            buffered <= 1'b0;
            thresh   <= THR_MIN;
         end
      end else if (cfg_we) begin
         buffered <= cfg_buffered;
         thresh   <= (cfg_thresh == '0) ? THR_MIN : cfg_thresh;
         lock_q   <= cfg_lock;
      end
   end
endmodule

// File: rtl/dskbuf_store.sv
module dskbuf_store #(
   parameter int WIDTH = 8,
   parameter int DEPTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             push,
   input  logic             pop,
   input  logic [WIDTH-1:0] wdata,
   output logic [WIDTH-1:0] head
);
   localparam int PW = $clog2(DEPTH);

   logic [PW-1:0]    wr_ptr;
   logic [PW-1:0]    rd_ptr;
   logic [WIDTH-1:0] slot_q [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
      end else begin
         if (push) wr_ptr <= wr_ptr + PW'(1);
         if (pop)  rd_ptr <= rd_ptr + PW'(1);
      end
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic [WIDTH-1:0] q;
      always_ff @(posedge clk) begin
         if (push && !flush && (wr_ptr == PW'(i))) q <= wdata;
      end
      assign slot_q[i] = q;
   end

   assign head = slot_q[rd_ptr];
endmodule

// File: rtl/dskbuf_ctrl.sv
module dskbuf_ctrl
   import dskbuf_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int TW    = 4,
   parameter int CW    = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  xfer_dir_e     dir,
   input  logic          buffered,
   input  logic [TW-1:0] thresh,
   input  logic          push_req,
   input  logic          pop_req,
   output logic          push_ok,
   output logic          pop_ok,
   output logic [CW-1:0] count,
   output err_flags_t    flags,
   output logic          svc
);
   localparam logic [CW-1:0] FULL_DEPTH   = CW'(DEPTH);
   localparam logic [CW-1:0] LEGACY_DEPTH = CW'(1);

   logic [CW-1:0] eff_depth;
   logic          active;
   logic          room;
   logic          unr_ev;
   logic          ovr_ev;
   logic [CW-1:0] thr_w;
   logic          svc_raw;

   assign eff_depth = buffered ? FULL_DEPTH : LEGACY_DEPTH;
   assign active    = !(flags.ovr || flags.unr);
   assign pop_ok    = active && pop_req && (count != '0);
   assign unr_ev    = active && (dir == XFER_TO_DISK) && pop_req && (count == '0);
   assign room      = (count < eff_depth) || pop_ok;
   assign push_ok   = active && push_req && !unr_ev && room;
   assign ovr_ev    = active && (dir == XFER_TO_HOST) && push_req && !room;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
         flags <= '0;
      end else if (flush) begin
         count <= '0;
         flags <= '0;
      end else begin
         count     <= count + CW'(push_ok) - CW'(pop_ok);
         flags.ovr <= flags.ovr | ovr_ev;
         flags.unr <= flags.unr | unr_ev;
      end
   end

   assign thr_w = CW'(thresh);

   always_comb begin
      if (dir == XFER_TO_HOST)
         svc_raw = buffered ? (count >= (FULL_DEPTH - thr_w)) : (count != '0);
      else
         svc_raw = buffered ? (count <= thr_w) : (count == '0);
   end

   assign svc = svc_raw && active;
endmodule

// File: rtl/dskbuf_top.sv
module dskbuf_top
   import dskbuf_pkg::*;
#(
   parameter int WIDTH = 8,
   parameter int DEPTH = 16,
   parameter int TW    = $clog2(DEPTH),
   parameter int CW    = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sw_reset,
   input  logic             exec_start,
   input  logic             cfg_we,
   input  logic             cfg_buffered,
   input  logic [TW-1:0]    cfg_thresh,
   input  logic             cfg_lock,
   input  logic             dir_write,
   input  logic             host_we,
   input  logic [WIDTH-1:0] host_wdata,
   input  logic             host_re,
   output logic [WIDTH-1:0] host_rdata,
   input  logic             disk_push,
   input  logic [WIDTH-1:0] disk_wdata,
   input  logic             disk_pop,
   output logic [WIDTH-1:0] disk_rdata,
   output logic             svc_req,
   output logic [CW-1:0]    level,
   output logic             overrun,
   output logic             underrun,
   output logic             term
);
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("dskbuf_top: DEPTH must be a power of two of at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("dskbuf_top: WIDTH must be positive");
   end
   if (TW != $clog2(DEPTH) || CW != $clog2(DEPTH + 1)) begin : g_bad_derived
      $error("dskbuf_top: TW and CW must keep their derived values");
   end

   xfer_dir_e        dir;
   logic             buffered;
   logic [TW-1:0]    thresh;
   logic             flush;
   logic             push_req, pop_req, push_ok, pop_ok;
   logic [WIDTH-1:0] wdata, head;
   err_flags_t       flags;

   assign dir     = xfer_dir_e'(dir_write);
   assign flush   = sw_reset | exec_start;
   assign push_req = (dir == XFER_TO_DISK) ? host_we    : disk_push;
   assign pop_req  = (dir == XFER_TO_DISK) ? disk_pop   : host_re;
   assign wdata    = (dir == XFER_TO_DISK) ? host_wdata : disk_wdata;

   dskbuf_mode #(.TW(TW)) u_mode (
      .clk          (clk),
      .rst_n        (rst_n),
      .sw_reset     (sw_reset),
      .cfg_we       (cfg_we),
      .cfg_buffered (cfg_buffered),
      .cfg_thresh   (cfg_thresh),
      .cfg_lock     (cfg_lock),
      .buffered     (buffered),
      .thresh       (thresh)
   );

   dskbuf_ctrl #(.DEPTH(DEPTH), .TW(TW), .CW(CW)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (flush),
      .dir      (dir),
      .buffered (buffered),
      .thresh   (thresh),
      .push_req (push_req),
      .pop_req  (pop_req),
      .push_ok  (push_ok),
      .pop_ok   (pop_ok),
      .count    (level),
      .flags    (flags),
      .svc      (svc_req)
   );

   dskbuf_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (flush),
      .push  (push_ok),
      .pop   (pop_ok),
      .wdata (wdata),
      .head  (head)
   );

   assign overrun    = flags.ovr;
   assign underrun   = flags.unr;
   assign term       = flags.ovr | flags.unr;
   assign host_rdata = head;
   assign disk_rdata = flags.unr ? '0 : head;
endmodule

// File: rtl/dskbuf_chk.sv
module dskbuf_chk #(
   parameter int WIDTH = 8,
   parameter int DEPTH = 16,
   parameter int TW    = $clog2(DEPTH),
   parameter int CW    = $clog2(DEPTH + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sw_reset,
   input logic             exec_start,
   input logic             dir_write,
   input logic             host_we,
   input logic             host_re,
   input logic             disk_push,
   input logic             disk_pop,
   input logic [WIDTH-1:0] disk_rdata,
   input logic             svc_req,
   input logic [CW-1:0]    level,
   input logic             overrun,
   input logic             underrun,
   input logic             term
);
   p_level_max_r2: assert property (@(posedge clk) disable iff (!rst_n)
      level <= CW'(DEPTH));

   p_pushpop_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!dir_write && disk_push && host_re && level != '0 && !term && !sw_reset && !exec_start)
      |=> (level == $past(level)));

   p_pad_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      underrun |-> (disk_rdata == '0));

   p_overrun_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (overrun && !exec_start && !sw_reset) |=> overrun);

   p_no_svc_term_r9: assert property (@(posedge clk) disable iff (!rst_n)
      term |-> !svc_req);

   p_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (term && !exec_start && !sw_reset) |=> (level == $past(level)));

   p_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
      exec_start |=> (level == '0 && !overrun && !underrun));
endmodule

bind dskbuf_top dskbuf_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH), .TW(TW), .CW(CW)) u_chk (.*);

// File: tb/dskbuf_top_tb.sv
module dskbuf_top_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sw_reset = 0, exec_start = 0, cfg_we = 0, cfg_buffered = 0, cfg_lock = 0;
   logic [3:0] cfg_thresh = 0;
   logic       dir_write = 0, host_we = 0, host_re = 0, disk_push = 0, disk_pop = 0;
   logic [7:0] host_wdata = 0, disk_wdata = 0;
   logic [7:0] host_rdata, disk_rdata;
   logic       svc_req, overrun, underrun, term;
   logic [4:0] level;

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   // reference model state
   byte unsigned q[$];
   bit m_buf, m_lock, m_ovr, m_unr;
   int m_thr;

   always #10 clk = ~clk;

   dskbuf_top u_dut (.*);

   task automatic chk(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
      end
   endtask

   function automatic bit exp_svc();
      int n = q.size();
      if (m_ovr || m_unr) return 0;
      if (dir_write) return m_buf ? (n <= m_thr) : (n == 0);
      return m_buf ? (n >= 16 - m_thr) : (n >= 1);
   endfunction

   task automatic model_edge();
      bit ob = m_buf;
      if (sw_reset) begin
         q.delete(); m_ovr = 0; m_unr = 0;
         if (!m_lock) begin m_buf = 0; m_thr = 1; end
      end else begin
         if (exec_start) begin
            q.delete(); m_ovr = 0; m_unr = 0;
         end else if (!(m_ovr || m_unr)) begin
            int  eff  = ob ? 16 : 1;
            bit  pu   = dir_write ? host_we : disk_push;
            bit  po   = dir_write ? disk_pop : host_re;
            byte unsigned wd = dir_write ? host_wdata : disk_wdata;
            bit  pok  = po && q.size() > 0;
            bit  unr  = dir_write && po && q.size() == 0;
            bit  room = (q.size() < eff) || pok;
            bit  uok  = pu && !unr && room;
            if (!dir_write && pu && !room) m_ovr = 1;
            if (unr) m_unr = 1;
            if (pok) void'(q.pop_front());
            if (uok) q.push_back(wd);
         end
         if (cfg_we) begin
            m_buf = cfg_buffered; m_thr = (cfg_thresh == 0) ? 1 : cfg_thresh; m_lock = cfg_lock;
         end
      end
   endtask

   task automatic compare_all();
      string st = m_buf ? (dir_write ? "R5" : "R4") : "R6";
      chk("R2 level", level, q.size());
      chk({st, " svc_req"}, svc_req, exp_svc());
      chk("R7 overrun", overrun, m_ovr);
      chk("R8 underrun", underrun, m_unr);
      chk("R9 term", term, m_ovr | m_unr);
      if (q.size() > 0) chk("R2 host_rdata", host_rdata, q[0]);
      if (m_unr) chk("R8 disk_rdata pad", disk_rdata, 0);
      else if (q.size() > 0) chk("R2 disk_rdata", disk_rdata, q[0]);
   endtask

   task automatic cyc();
      @(posedge clk);
      model_edge();
      #1;
      compare_all();
      sw_reset = 0; exec_start = 0; cfg_we = 0;
      host_we = 0; host_re = 0; disk_push = 0; disk_pop = 0;
   endtask

   task automatic configure(bit b, int t, bit l);
      cfg_we = 1; cfg_buffered = b; cfg_thresh = 4'(t); cfg_lock = l; cyc();
   endtask

   task automatic dpush(byte unsigned v); disk_push = 1; disk_wdata = v; cyc(); endtask
   task automatic hpush(byte unsigned v); host_we = 1; host_wdata = v; cyc(); endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      m_buf = 0; m_thr = 1; m_lock = 0; m_ovr = 0; m_unr = 0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      // R1 reset state
      cyc();
      chk("R1 level", level, 0); chk("R1 svc_req read", svc_req, 0); chk("R1 term", term, 0);
      dir_write = 1; #1;
      chk("R1 svc_req write", svc_req, 1);
      dir_write = 0;
      // R12 configure buffered thr 8, R4 threshold crossing
      configure(1, 8, 0);
      for (int i = 0; i < 16; i++) begin
         dpush(8'(i + 8'h30));
         chk("R4 svc at threshold", svc_req, (i + 1 >= 8) ? 1 : 0);
      end
      // R3 full push+pop
      disk_push = 1; disk_wdata = 8'hAA; host_re = 1; cyc();
      chk("R3 level held", level, 16);
      chk("R2 order", host_rdata, 8'h31);
      // R7 overrun on full
      dpush(8'hBB);
      chk("R7 overrun set", overrun, 1); chk("R7 level", level, 16);
      // R9 ignored after term
      host_re = 1; cyc();
      chk("R9 pop ignored", level, 16); chk("R9 svc low", svc_req, 0);
      // R10 flush
      exec_start = 1; cyc();
      chk("R10 level", level, 0); chk("R10 overrun clear", overrun, 0);
      // R5 / R8 write direction underrun
      dir_write = 1;
      hpush(8'h11); hpush(8'h22); hpush(8'h33);
      chk("R5 svc level 3", svc_req, 1);
      repeat (3) begin disk_pop = 1; cyc(); end
      disk_pop = 1; host_we = 1; host_wdata = 8'h44; cyc();
      chk("R8 underrun", underrun, 1); chk("R8 pad", disk_rdata, 0); chk("R8 push dropped", level, 0);
      exec_start = 1; cyc();
      dir_write = 0;
      // R12 threshold 0 stored as 1
      configure(1, 0, 0);
      for (int i = 0; i < 15; i++) dpush(8'(i));
      chk("R12 svc at 15", svc_req, 1);
      exec_start = 1; cyc();
      for (int i = 0; i < 14; i++) dpush(8'(i));
      chk("R12 svc at 14", svc_req, 0);
      // R11 soft reset with lock 0 -> compatible
      sw_reset = 1; cyc();
      chk("R11 flushed", level, 0);
      dpush(8'h5A);
      chk("R6 compat svc", svc_req, 1);
      dpush(8'h5B);
      chk("R6 compat overrun", overrun, 1);
      // R11 lock 1 keeps buffered mode
      configure(1, 4, 1);
      sw_reset = 1; cyc();
      dpush(8'h01); dpush(8'h02);
      chk("R11 locked buffered", overrun, 0); chk("R11 locked level", level, 2);
      // random phase
      for (int n = 0; n < 6000; n++) begin
         int r = $urandom_range(0, 999);
         if (r < 2) sw_reset = 1;
         else if (r < 20) begin exec_start = 1; dir_write = $urandom_range(0, 1); end
         else if (r < 28) begin
            cfg_we = 1; cfg_buffered = ($urandom_range(0, 3) != 0);
            cfg_thresh = 4'($urandom_range(0, 15)); cfg_lock = $urandom_range(0, 1);
         end
         host_we = $urandom_range(0, 1); host_re = $urandom_range(0, 1);
         disk_push = $urandom_range(0, 1); disk_pop = ($urandom_range(0, 2) == 0);
         host_wdata = 8'($urandom); disk_wdata = 8'($urandom);
         cyc();
      end
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule